// File: doc/BRIEF.md
# Spare Channel Failover Controller

This block watches a small memory subsystem of several working channels plus one extra channel held in reserve. Each working channel reports correctable-error events as single-cycle pulses. The controller counts those events per channel inside a repeating window of programmable length. When a channel reaches the programmable limit inside one window, the controller moves that channel's whole contents to the reserve channel on its own. It then points the affected host slot at the reserve and retires the worn channel. No host action is needed at any point.

Hosts reach memory through one logical slot each. Each slot has a simple request port: request, write enable, address and write data, with read data returned one cycle later. The controller routes every slot to a physical channel through a remap table. While the migration runs, it holds the slot that belongs to the failing channel with a stall flag, so that the copy reads a stable image. The other slots keep running without interruption. Uncorrectable events are latched and shown on a flag output, but they never start a migration. The reserve can be used only once. Any later limit crossing raises a sticky alarm.

Top module: `spare_failover_ctrl`

## Requirements
- R1: After reset, slot i maps to physical channel i (remap_table field i, CH_W bits wide at bit i*CH_W, holds i). No channel is offline. copy_busy, spare_used, spare_alarm, host_stall and ue_seen are all zero.
- R2: Before failover, a slot request reaches only its mapped channel with the same address, write enable and data. Read data appears on host_rdata one cycle after the request. The reserve channel (the highest index) gets no requests at all.
- R3: A channel that is in service trips when its correctable-error count inside the current window reaches cfg_threshold (threshold 3 needs the third pulse). Fewer pulses in a window do not trip it.
- R4: All error counters clear at the last cycle of each window of cfg_window cycles. A pulse that lands in that clearing cycle is discarded. Pulses from earlier windows never add to a later window's count.
- R5: An uncorrectable pulse on channel c sets ue_seen[c], which stays set until reset. It never starts a migration and never changes the error counters.
- R6: After a trip, the controller reads address a of the failing channel and writes the returned word to address a of the reserve on the next cycle. It does this for a = 0 up to the last address, in ascending order. copy_busy stays high for 2*2^ADDR_W + 1 cycles, the last of which is the remap cycle.
- R7: While copy_busy is high, host_stall is set only for the slot mapped to the failing channel, and that slot's requests are not forwarded. Every other slot keeps reading and writing its own channel.
- R8: When the copy finishes, the failing slot's remap field becomes the reserve index, ch_offline[failing] is set and spare_used goes high. From then on, that slot's accesses reach the reserve channel and find the copied data.
- R9: Only one failover ever happens. Any trip once the copy has started sets spare_alarm, which stays set until reset. The remap table and the offline flags do not change.
- R10: An offline channel receives no requests, and its correctable pulses are ignored. They raise no alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_threshold | input | CNT_W | Error count per window that trips a channel (0 disables) |
| cfg_window | input | WIN_W | Window length in cycles |
| ce_pulse | input | NUM_CH | Correctable-error event per physical channel |
| ue_pulse | input | NUM_CH | Uncorrectable-error event per physical channel |
| host_req | input | NUM_ACT | Request per logical slot |
| host_we | input | NUM_ACT | Write enable per slot |
| host_addr | input | NUM_ACT*ADDR_W | Address per slot |
| host_wdata | input | NUM_ACT*DATA_W | Write data per slot |
| host_rdata | output | NUM_ACT*DATA_W | Read data per slot, one cycle after the request |
| host_stall | output | NUM_ACT | Slot held during migration |
| ch_req | output | NUM_CH | Request per physical channel |
| ch_we | output | NUM_CH | Write enable per channel |
| ch_addr | output | NUM_CH*ADDR_W | Address per channel |
| ch_wdata | output | NUM_CH*DATA_W | Write data per channel |
| ch_rdata | input | NUM_CH*DATA_W | Read data per channel, one cycle latency |
| remap_table | output | NUM_ACT*CH_W | Physical channel serving each slot |
| ch_offline | output | NUM_CH | Retired channel flags |
| copy_busy | output | 1 | Migration in progress |
| spare_used | output | 1 | Reserve channel in service |
| spare_alarm | output | 1 | Sticky: a trip happened after the reserve was taken |
| ue_seen | output | NUM_CH | Sticky uncorrectable-error flags |

## Verification
The assertions check the following on every cycle: the reserve gets no traffic until it is in use, it only receives writes during the copy, offline channels stay silent, at most one channel is ever retired, the alarm is sticky, and the state is frozen after failover. Only the bench scenarios can show the rest. These are: that the copy visits every address in ascending order with the right data, that it takes the stated number of cycles, that the window clearing discards stale events, that the unaffected slot's writes made during the copy survive, and that the remapped slot finds the copied contents.

// File: rtl/sfo_pkg.sv
package sfo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COPY_READ,
      ST_COPY_WRITE,
      ST_REMAP,
      ST_DONE
   } mig_state_e;
endpackage

// File: rtl/ce_window_counter.sv
module ce_window_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  logic             enable,
   input  logic             ce,
   input  logic [CNT_W-1:0] thr,
   output logic             trip
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (win_end)
         cnt_q <= '0;
      else if (enable && ce && (cnt_q != {CNT_W{1'b1}}))
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // trip on the event that brings the count up to the threshold
   assign trip = enable && ce && !win_end && (thr != '0) &&
                 (cnt_q == thr - CNT_W'(1));
endmodule

// File: rtl/migrate_fsm.sv
module migrate_fsm
   import sfo_pkg::*;
#(
   parameter int NUM_ACT = 2,
   parameter int NUM_CH  = 3,
   parameter int ADDR_W  = 4,
   parameter int CH_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         trip,
   output mig_state_e                state,
   output logic [CH_W-1:0]           fail_ch,
   output logic [ADDR_W-1:0]         copy_addr,
   output logic [NUM_ACT*CH_W-1:0]   map_flat,
   output logic [NUM_CH-1:0]         offline,
   output logic                      alarm
);
   localparam logic [CH_W-1:0]   SPARE = CH_W'(NUM_CH - 1);
   localparam logic [ADDR_W-1:0] LAST  = {ADDR_W{1'b1}};

   mig_state_e        state_q;
   logic [CH_W-1:0]   fail_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CH_W-1:0]   map_q [NUM_ACT];
   logic [NUM_CH-1:0] off_q;
   logic              alarm_q;
   logic              any_trip;
   logic [CH_W-1:0]   first_trip;

   assign any_trip = |trip;

   always_comb begin
      first_trip = '0;
      for (int c = NUM_CH - 1; c >= 0; c--)
         if (trip[c]) first_trip = CH_W'(c);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fail_q  <= '0;
         addr_q  <= '0;
         off_q   <= '0;
         alarm_q <= 1'b0;
         for (int i = 0; i < NUM_ACT; i++) map_q[i] <= CH_W'(i);
      end else begin
         if (any_trip && state_q != ST_IDLE) alarm_q <= 1'b1;
         case (state_q)
            ST_IDLE: if (any_trip) begin
               state_q <= ST_COPY_READ;
               fail_q  <= first_trip;
               addr_q  <= '0;
            end
            ST_COPY_READ: state_q <= ST_COPY_WRITE;
            ST_COPY_WRITE: begin
               if (addr_q == LAST) state_q <= ST_REMAP;
               else begin
                  addr_q  <= addr_q + ADDR_W'(1);
                  state_q <= ST_COPY_READ;
               end
            end
            ST_REMAP: begin
               for (int i = 0; i < NUM_ACT; i++)
                  if (map_q[i] == fail_q) map_q[i] <= SPARE;
               off_q[fail_q] <= 1'b1;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_DONE;
         endcase
      end
   end

   always_comb
      for (int i = 0; i < NUM_ACT; i++) map_flat[i*CH_W +: CH_W] = map_q[i];

   assign state     = state_q;
   assign fail_ch   = fail_q;
   assign copy_addr = addr_q;
   assign offline   = off_q;
   assign alarm     = alarm_q;
endmodule

// File: rtl/chan_router.sv
module chan_router #(
   parameter int NUM_ACT = 2,
   parameter int NUM_CH  = 3,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 16,
   parameter int CH_W    = 2
) (
   input  logic [NUM_ACT-1:0]        host_req,
   input  logic [NUM_ACT-1:0]        host_we,
   input  logic [NUM_ACT*ADDR_W-1:0] host_addr,
   input  logic [NUM_ACT*DATA_W-1:0] host_wdata,
   output logic [NUM_ACT*DATA_W-1:0] host_rdata,
   output logic [NUM_ACT-1:0]        host_stall,
   input  logic [NUM_ACT*CH_W-1:0]   map_flat,
   input  logic                      hold,
   input  logic [CH_W-1:0]           fail_ch,
   input  logic                      copy_rd,
   input  logic                      copy_wr,
   input  logic [ADDR_W-1:0]         copy_addr,
   output logic [NUM_CH-1:0]         ch_req,
   output logic [NUM_CH-1:0]         ch_we,
   output logic [NUM_CH*ADDR_W-1:0]  ch_addr,
   output logic [NUM_CH*DATA_W-1:0]  ch_wdata,
   input  logic [NUM_CH*DATA_W-1:0]  ch_rdata
);
   localparam int SPARE = NUM_CH - 1;

   always_comb begin
      ch_req     = '0;
      ch_we      = '0;
      ch_addr    = '0;
      ch_wdata   = '0;
      host_stall = '0;
      host_rdata = '0;
      for (int i = 0; i < NUM_ACT; i++) begin
         int p;
         p = int'(map_flat[i*CH_W +: CH_W]);
         host_stall[i] = hold && (map_flat[i*CH_W +: CH_W] == fail_ch);
         host_rdata[i*DATA_W +: DATA_W] = ch_rdata[p*DATA_W +: DATA_W];
         if (host_req[i] && !host_stall[i]) begin
            ch_req[p] = 1'b1;
            ch_we[p]  = host_we[i];
            ch_addr[p*ADDR_W +: ADDR_W]  = host_addr[i*ADDR_W +: ADDR_W];
            ch_wdata[p*DATA_W +: DATA_W] = host_wdata[i*DATA_W +: DATA_W];
         end
      end
      if (copy_rd) begin
         ch_req[fail_ch] = 1'b1;
         ch_we[fail_ch]  = 1'b0;
         ch_addr[int'(fail_ch)*ADDR_W +: ADDR_W] = copy_addr;
      end
      if (copy_wr) begin
         ch_req[SPARE] = 1'b1;
         ch_we[SPARE]  = 1'b1;
         ch_addr[SPARE*ADDR_W +: ADDR_W]  = copy_addr;
         ch_wdata[SPARE*DATA_W +: DATA_W] = ch_rdata[int'(fail_ch)*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/spare_failover_ctrl.sv
module spare_failover_ctrl
   import sfo_pkg::*;
#(
   parameter int NUM_ACT  = 2,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int WIN_W    = 16,
   localparam int NUM_CH  = NUM_ACT + 1,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CNT_W-1:0]          cfg_threshold,
   input  logic [WIN_W-1:0]          cfg_window,
   input  logic [NUM_CH-1:0]         ce_pulse,
   input  logic [NUM_CH-1:0]         ue_pulse,
   input  logic [NUM_ACT-1:0]        host_req,
   input  logic [NUM_ACT-1:0]        host_we,
   input  logic [NUM_ACT*ADDR_W-1:0] host_addr,
   input  logic [NUM_ACT*DATA_W-1:0] host_wdata,
   output logic [NUM_ACT*DATA_W-1:0] host_rdata,
   output logic [NUM_ACT-1:0]        host_stall,
   output logic [NUM_CH-1:0]         ch_req,
   output logic [NUM_CH-1:0]         ch_we,
   output logic [NUM_CH*ADDR_W-1:0]  ch_addr,
   output logic [NUM_CH*DATA_W-1:0]  ch_wdata,
   input  logic [NUM_CH*DATA_W-1:0]  ch_rdata,
   output logic [NUM_ACT*CH_W-1:0]   remap_table,
   output logic [NUM_CH-1:0]         ch_offline,
   output logic                      copy_busy,
   output logic                      spare_used,
   output logic                      spare_alarm,
   output logic [NUM_CH-1:0]         ue_seen
);
   if (NUM_ACT < 1) begin : g_bad_act
      $error("NUM_ACT must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be at least 1");
   end
   if (CNT_W < 2 || WIN_W < 2) begin : g_bad_cnt
      $error("CNT_W and WIN_W must be at least 2");
   end

   mig_state_e        state;
   logic [CH_W-1:0]   fail_ch;
   logic [ADDR_W-1:0] copy_addr;
   logic [NUM_CH-1:0] trip;
   logic [NUM_CH-1:0] mon_en;
   logic [NUM_CH-1:0] ue_q;
   logic [WIN_W-1:0]  wcnt_q;
   logic              win_end;
   logic              busy;

   assign win_end = (wcnt_q >= cfg_window - WIN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) wcnt_q <= '0;
      else        wcnt_q <= win_end ? '0 : wcnt_q + WIN_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ue_q <= '0;
      else        ue_q <= ue_q | ue_pulse;
   end

   assign busy = (state == ST_COPY_READ) || (state == ST_COPY_WRITE) ||
                 (state == ST_REMAP);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mon
      if (c == NUM_CH - 1) begin : g_spare
         assign mon_en[c] = (state == ST_DONE);
      end else begin : g_work
         assign mon_en[c] = !ch_offline[c] && !(busy && fail_ch == CH_W'(c));
      end
      ce_window_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .win_end (win_end),
         .enable  (mon_en[c]),
         .ce      (ce_pulse[c]),
         .thr     (cfg_threshold),
         .trip    (trip[c])
      );
   end

   migrate_fsm #(
      .NUM_ACT(NUM_ACT), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trip      (trip),
      .state     (state),
      .fail_ch   (fail_ch),
      .copy_addr (copy_addr),
      .map_flat  (remap_table),
      .offline   (ch_offline),
      .alarm     (spare_alarm)
   );

   chan_router #(
      .NUM_ACT(NUM_ACT), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .CH_W(CH_W)
   ) u_route (
      .host_req   (host_req),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .host_stall (host_stall),
      .map_flat   (remap_table),
      .hold       (busy),
      .fail_ch    (fail_ch),
      .copy_rd    (state == ST_COPY_READ),
      .copy_wr    (state == ST_COPY_WRITE),
      .copy_addr  (copy_addr),
      .ch_req     (ch_req),
      .ch_we      (ch_we),
      .ch_addr    (ch_addr),
      .ch_wdata   (ch_wdata),
      .ch_rdata   (ch_rdata)
   );

   assign copy_busy  = busy;
   assign spare_used = (state == ST_DONE);
   assign ue_seen    = ue_q;
endmodule

// File: rtl/failover_checker.sv
module failover_checker #(
   parameter int NUM_ACT = 2,
   parameter int NUM_CH  = 3,
   parameter int CH_W    = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH-1:0]       ch_req,
   input logic [NUM_CH-1:0]       ch_we,
   input logic [NUM_CH-1:0]       ch_offline,
   input logic [NUM_ACT-1:0]      host_stall,
   input logic [NUM_ACT*CH_W-1:0] remap_table,
   input logic                    copy_busy,
   input logic                    spare_used,
   input logic                    spare_alarm
);
   localparam int SPARE = NUM_CH - 1;

   p_spare_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!spare_used && !copy_busy) |-> !ch_req[SPARE]);

   p_copy_writes_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_busy && ch_req[SPARE]) |-> ch_we[SPARE]);

   p_stall_during_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      copy_busy |-> $countones(host_stall) >= 1);

   p_no_stall_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_busy |-> (host_stall == '0));

   p_frozen_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spare_used |=> (spare_used && $stable(ch_offline) && $stable(remap_table)));

   p_single_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ch_offline) <= 1);

   p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spare_alarm |=> spare_alarm);

   p_offline_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_req & ch_offline) == '0);
endmodule

bind spare_failover_ctrl failover_checker #(
   .NUM_ACT(NUM_ACT), .NUM_CH(NUM_CH), .CH_W(CH_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ch_req      (ch_req),
   .ch_we       (ch_we),
   .ch_offline  (ch_offline),
   .host_stall  (host_stall),
   .remap_table (remap_table),
   .copy_busy   (copy_busy),
   .spare_used  (spare_used),
   .spare_alarm (spare_alarm)
);

// File: tb/test_spare_failover_ctrl.sv
module test_spare_failover_ctrl;
   localparam int NA = 2, NC = 3, AW = 4, DW = 16, CW = 8, WW = 16, CHW = 2;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic [CW-1:0]    cfg_threshold = 8'd3;
   logic [WW-1:0]    cfg_window = 16'd60000;
   logic [NC-1:0]    ce_pulse = '0, ue_pulse = '0;
   logic [NA-1:0]    host_req = '0, host_we = '0;
   logic [NA*AW-1:0] host_addr = '0;
   logic [NA*DW-1:0] host_wdata = '0;
   logic [NA*DW-1:0] host_rdata;
   logic [NA-1:0]    host_stall;
   logic [NC-1:0]    ch_req, ch_we, ch_offline, ue_seen;
   logic [NC*AW-1:0] ch_addr;
   logic [NC*DW-1:0] ch_wdata, ch_rdata;
   logic [NA*CHW-1:0] remap_table;
   logic copy_busy, spare_used, spare_alarm;

   spare_failover_ctrl #(.NUM_ACT(NA), .ADDR_W(AW), .DATA_W(DW),
                         .CNT_W(CW), .WIN_W(WW)) i_spare_failover_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
      .cfg_window(cfg_window), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_stall(host_stall),
      .ch_req(ch_req), .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
      .ch_rdata(ch_rdata), .remap_table(remap_table), .ch_offline(ch_offline),
      .copy_busy(copy_busy), .spare_used(spare_used),
      .spare_alarm(spare_alarm), .ue_seen(ue_seen));

   // channel memory model with one-cycle read latency and a backdoor fill
   logic [DW-1:0] mem [NC][DEPTH];
   logic [DW-1:0] rdq [NC];
   logic          bd_we = 1'b0;
   logic [AW-1:0] bd_addr = '0;
   logic [DW-1:0] bd_data = '0;
   logic          ctr_clr = 1'b0;
   int seq_err = 0, seq_cnt = 0, spare_host = 0, off_req = 0;

   always @(posedge clk) begin
      if (bd_we) mem[0][bd_addr] <= bd_data;
      for (int c = 0; c < NC; c++)
         if (ch_req[c]) begin
            if (ch_we[c]) mem[c][ch_addr[c*AW +: AW]] <= ch_wdata[c*DW +: DW];
            else          rdq[c] <= mem[c][ch_addr[c*AW +: AW]];
         end
      if (ctr_clr) begin
         seq_err <= 0; seq_cnt <= 0; spare_host <= 0; off_req <= 0;
      end else begin
         if (ch_req[2] && !copy_busy && !spare_used) spare_host <= spare_host + 1;
         if ((ch_req & ch_offline) != '0) off_req <= off_req + 1;
         if (copy_busy && ch_req[2]) begin
            if (!ch_we[2] || ch_addr[2*AW +: AW] != AW'(seq_cnt) ||
                ch_wdata[2*DW +: DW] != mem[0][ch_addr[2*AW +: AW]])
               seq_err <= seq_err + 1;
            seq_cnt <= seq_cnt + 1;
         end
      end
   end
   always_comb for (int c = 0; c < NC; c++) ch_rdata[c*DW +: DW] = rdq[c];

   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; host_req = '0; ce_pulse = '0; ue_pulse = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic hwrite(input int s, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_req[s] = 1'b1; host_we[s] = 1'b1;
      host_addr[s*AW +: AW] = a; host_wdata[s*DW +: DW] = d;
      @(negedge clk);
      host_req[s] = 1'b0;
   endtask

   task automatic hread(input int s, input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      host_req[s] = 1'b1; host_we[s] = 1'b0; host_addr[s*AW +: AW] = a;
      @(negedge clk);
      host_req[s] = 1'b0;
      d = host_rdata[s*DW +: DW];
   endtask

   task automatic pulse_ce(input int c);
      @(negedge clk); ce_pulse[c] = 1'b1;
      @(negedge clk); ce_pulse[c] = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(16'h5A00 + a * 7);
   endfunction

   typedef struct packed { logic slot; logic [AW-1:0] addr; logic [DW-1:0] data; } vec_t;
   localparam vec_t VEC [6] = '{
      '{1'b0, 4'h1, 16'h1111}, '{1'b1, 4'h1, 16'h2222},
      '{1'b0, 4'hE, 16'hA5C3}, '{1'b1, 4'h7, 16'h0F0F},
      '{1'b0, 4'h0, 16'hFFFF}, '{1'b1, 4'hF, 16'h8001}};

   initial begin
      logic [DW-1:0] rd;
      int n, stall_bad, last_a;
      logic [DW-1:0] last_d;

      // window clearing scenario
      do_reset();
      cfg_threshold = 8'd3; cfg_window = 16'd8;
      pulse_ce(1); pulse_ce(1);
      repeat (20) @(negedge clk);
      pulse_ce(1); pulse_ce(1);
      repeat (3) @(negedge clk);
      chk(!copy_busy && ch_offline == '0, "R4 stale events cleared", copy_busy, 0);
      cfg_window = 16'd60000;
      pulse_ce(1); pulse_ce(1); pulse_ce(1);
      chk(copy_busy == 1'b1, "R3 trip after threshold reached", copy_busy, 1);

      // main scenario
      do_reset();
      cfg_threshold = 8'd3; cfg_window = 16'd60000;
      @(negedge clk); ctr_clr = 1'b1; @(negedge clk); ctr_clr = 1'b0;
      chk(remap_table == 4'b0100, "R1 reset remap", remap_table, 4'b0100);
      chk(ch_offline == '0 && !copy_busy && !spare_used && !spare_alarm &&
          host_stall == '0 && ue_seen == '0, "R1 reset flags",
          {ch_offline, copy_busy, spare_used, spare_alarm}, 0);

      foreach (VEC[i]) hwrite(int'(VEC[i].slot), VEC[i].addr, VEC[i].data);
      foreach (VEC[i]) begin
         hread(int'(VEC[i].slot), VEC[i].addr, rd);
         chk(rd == VEC[i].data, "R2 routed read", rd, VEC[i].data);
      end
      chk(mem[1][4'h1] == 16'h2222 && mem[0][4'h1] == 16'h1111,
          "R2 slot to own channel", mem[1][4'h1], 16'h2222);
      chk(spare_host == 0, "R2 reserve untouched", spare_host, 0);

      repeat (5) begin
         @(negedge clk); ue_pulse[0] = 1'b1;
         @(negedge clk); ue_pulse[0] = 1'b0;
      end
      chk(ue_seen == 3'b001 && !copy_busy, "R5 uncorrectable latched only",
          ue_seen, 3'b001);

      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk); bd_we = 1'b1; bd_addr = AW'(a); bd_data = pat(a);
      end
      @(negedge clk); bd_we = 1'b0;

      pulse_ce(0); pulse_ce(0);
      repeat (2) @(negedge clk);
      chk(!copy_busy, "R3 below threshold no trip", copy_busy, 0);
      pulse_ce(0);

      n = 0; stall_bad = 0; last_a = 0; last_d = '0;
      while (copy_busy && n < 100) begin
         if (host_stall != 2'b01) stall_bad++;
         n++;
         host_req = 2'b11; host_we = 2'b10;
         host_addr[AW +: AW] = AW'(n); host_wdata[DW +: DW] = DW'(16'hB000 + n);
         host_addr[0 +: AW] = AW'(n);
         last_a = n % DEPTH; last_d = DW'(16'hB000 + n);
         @(negedge clk);
      end
      host_req = '0;
      chk(n == 2 * DEPTH + 1, "R6 copy duration", n, 2 * DEPTH + 1);
      chk(seq_err == 0 && seq_cnt == DEPTH, "R6 copy order and data", seq_err, 0);
      chk(stall_bad == 0, "R7 only failing slot stalled", stall_bad, 0);
      hread(1, AW'(last_a), rd);
      chk(rd == last_d, "R7 other slot kept running", rd, last_d);

      chk(remap_table == 4'b0110, "R8 remap to reserve", remap_table, 4'b0110);
      chk(ch_offline == 3'b001 && spare_used, "R8 channel retired", ch_offline, 3'b001);
      for (int a = 0; a < DEPTH; a += 5) begin
         hread(0, AW'(a), rd);
         chk(rd == pat(a), "R8 copied data visible", rd, pat(a));
      end
      hwrite(0, 4'h3, 16'hCAFE);
      chk(mem[2][3] == 16'hCAFE && mem[0][3] == pat(3), "R8 writes land on reserve",
          mem[2][3], 16'hCAFE);

      repeat (5) pulse_ce(0);
      chk(!spare_alarm && !copy_busy, "R10 offline errors ignored", spare_alarm, 0);
      chk(off_req == 0, "R10 offline channel silent", off_req, 0);

      pulse_ce(1); pulse_ce(1); pulse_ce(1);
      @(negedge clk);
      chk(spare_alarm == 1'b1, "R9 alarm after reserve consumed", spare_alarm, 1);
      chk(!copy_busy && ch_offline == 3'b001 && remap_table == 4'b0110,
          "R9 no second failover", ch_offline, 3'b001);
      repeat (4) @(negedge clk);
      chk(spare_alarm == 1'b1, "R9 alarm sticky", spare_alarm, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule